// File: doc/BRIEF.md
# Watchdog Frequency Guard

This block keeps a board alive when its clock frequency is set by software. The host loads a time value into a down-counter and enables it. Each pulse on the 250 ms tick input takes one unit off the count. If software does not rearm the counter before it reaches zero, the block takes three recovery actions. It forces the effective frequency code to a recovery value, clears the direct M/N programming enable, and holds its active-low reset output low for a fixed number of tick periods.

The block also produces the 5-bit effective frequency-select code. That code comes from one of three places. The first is the board strap pins, captured once when the active-low power-good strobe first asserts. The second is a field in the host's frequency register. The third is the recovery code, which outranks both of the others from a timeout until the host next writes the frequency register.

There are four state machines:
- **Strap capture:** `S_WAIT`, then `S_HELD` on the first cycle with power-good low.
- **Counter:** `ST_IDLE`, `ST_RUN`, `ST_FIRE`.
  - `ST_IDLE`→`ST_RUN` when the enable is set with a nonzero count.
  - `ST_RUN`→`ST_IDLE` on stop or a zero write.
  - `ST_RUN`→`ST_FIRE` when a tick takes the count to zero.
  - `ST_FIRE`→`ST_IDLE` always, after one cycle.
- **Code selector:** `M_NORMAL`→`M_RECOVER` on fire, and `M_RECOVER`→`M_NORMAL` on a frequency register write.
- **Reset pulse:** `P_IDLE`→`P_LOW` on fire, and `P_LOW`→`P_IDLE` when the tick count runs out.

Top module: `wdt_freq_guard`

## Requirements
- R1: The strap code is captured on the first clock edge at which `pwrgd_n` is 0 after power-on reset. It then holds until the next power-on reset, whatever later values `strap_code` or `pwrgd_n` take. Before capture, the strap code is 0.
- R2: With no recovery active, `fsel_code` equals the strap code when `sw_sel_en` is 0. When `sw_sel_en` is 1, `fsel_code[3:0]` is `sw_field[7:4]` and `fsel_code[4]` is `sw_field[2]`.
- R3: After power-on reset, `wd_time` reads 8 (2.0 s at 250 ms per unit). While counting, it shows the live count, which drops by exactly one on each tick.
- R4: Writing the enable bit to 1 with a nonzero count starts counting. `wd_running` reads 1 while counting and 0 otherwise. Writing the enable bit to 0 stops the count and holds its value, so later ticks have no effect.
- R5: A nonzero time write while the enable bit is set restarts counting from the written value.
- R6: The cycle after a tick takes the count to zero, two things happen: `wd_timeout` reads 1 and `wd_running` reads 0. The status stays 1 through a time write made while stopped, and is cleared only when counting next starts.
- R7: On timeout, `fsel_code` becomes `safe_code` if `safe_sel` is 1, or the captured strap code if `safe_sel` is 0. That code holds, regardless of `sw_sel_en`, until a pulse on `code_wr`.
- R8: `mn_en` follows `mn_wr`/`mn_wdata` writes and is cleared on timeout. A timeout takes priority over a write in the same cycle.
- R9: `rst_out_n` goes to 0 in the same cycle `wd_timeout` rises. It returns to 1 on the edge that sees the PULSE_TICKS-th tick after the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | One-cycle pulse every 250 ms |
| pwrgd_n | input | 1 | Power-good strobe, active low; straps are valid while low |
| strap_code | input | 5 | Frequency-select strap pins |
| sw_sel_en | input | 1 | 1 selects the software frequency field |
| sw_field | input | 8 | Host frequency register byte (bits 7..4 and 2 used) |
| code_wr | input | 1 | Pulse when the host writes the frequency register |
| safe_sel | input | 1 | Recovery source: 1 safe code, 0 strap code |
| safe_code | input | 5 | Stored safe frequency code |
| wd_en_wr | input | 1 | Write strobe for the watchdog enable bit |
| wd_en_wdata | input | 1 | Enable value written |
| wd_time_wr | input | 1 | Write strobe for the time register |
| wd_time_wdata | input | 8 | Time value written, in 250 ms units |
| mn_wr | input | 1 | Write strobe for the M/N programming enable |
| mn_wdata | input | 1 | M/N enable value written |
| fsel_code | output | 5 | Effective frequency-select code |
| mn_en | output | 1 | M/N direct programming enable |
| wd_running | output | 1 | Enable readback: 1 while counting |
| wd_time | output | 8 | Time register readback (live count) |
| wd_timeout | output | 1 | Timeout status |
| rst_out_n | output | 1 | Reset output; 0 means pull the open-drain pin low |

## Verification
The bench builds the block with TIME_W = 8 and TIME_DEFAULT = 8, and with PULSE_TICKS = 2 rather than 1. A two-tick pulse separates a correct tick count from one that ends after the first tick. The bench drives the tick input itself, so a whole expiry needs only a few ticks from small time values. That puts both recovery sources, the override release and the full reset pulse within a few hundred cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CODE_W  = 5;
    localparam int FIELD_W = 8;

    typedef enum logic [0:0] {S_WAIT, S_HELD} strap_st_t;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIRE} tmr_st_t;
    typedef enum logic [0:0] {M_NORMAL, M_RECOVER} sel_st_t;
    typedef enum logic [0:0] {P_IDLE, P_LOW} pls_st_t;

    // Software field layout: code[3:0] from field[7:4], code[4] from field[2]
    function automatic logic [CODE_W-1:0] unpack_sw(input logic [FIELD_W-1:0] f);
        return {f[2], f[7:4]};
    endfunction

endpackage

// File: rtl/wdg_strap_latch.sv
module wdg_strap_latch
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              pwrgd_n,
    input  logic [CODE_W-1:0] strap_in,
    output logic [CODE_W-1:0] strap_q,
    output logic              held
);
    strap_st_t state_q, state_d;
    logic [CODE_W-1:0] code_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT: if (!pwrgd_n) state_d = S_HELD;
            S_HELD: state_d = S_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= S_WAIT;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_WAIT && !pwrgd_n)
                code_q <= strap_in;
        end
    end

    always_comb begin
        strap_q = code_q;
        held    = (state_q == S_HELD);
    end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
    parameter int TIME_W       = 8,
    parameter int TIME_DEFAULT = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tick,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              time_wr,
    input  logic [TIME_W-1:0] time_wdata,
    output logic [TIME_W-1:0] count,
    output logic              running,
    output logic              fire,
    output logic              timeout
);
    import wdg_pkg::*;

    localparam logic [TIME_W-1:0] CNT_RST = TIME_W'(TIME_DEFAULT);

    tmr_st_t           state_q, state_d;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    logic              en_q, en_d;
    logic              to_q;
    logic              start;

    always_comb begin
        if (en_wr)                 en_d = en_wdata;
        else if (state_q == ST_FIRE) en_d = 1'b0;
        else                       en_d = en_q;

        if (time_wr)
            cnt_d = time_wdata;
        else if (state_q == ST_RUN && tick && en_d)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;

        state_d = state_q;
        unique case (state_q)
            ST_FIRE: state_d = ST_IDLE;
            ST_IDLE: begin
                if (en_d && cnt_d != '0) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_d)
                    state_d = ST_IDLE;
                else if (cnt_d == '0)
                    state_d = time_wr ? ST_IDLE : ST_FIRE;
            end
            default: state_d = ST_IDLE;
        endcase

        start = (state_d == ST_RUN) && (state_q != ST_RUN || time_wr);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_RST;
            en_q    <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            en_q    <= en_d;
            if (state_q == ST_FIRE) to_q <= 1'b1;
            else if (start)         to_q <= 1'b0;
        end
    end

    always_comb begin
        count   = cnt_q;
        running = (state_q == ST_RUN);
        fire    = (state_q == ST_FIRE);
        timeout = to_q;
    end
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic start,
    output logic rst_n_out
);
    import wdg_pkg::*;

    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    pls_st_t       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            P_IDLE: begin
                if (start) begin
                    state_d = P_LOW;
                    cnt_d   = LOAD;
                end
            end
            P_LOW: begin
                if (start) begin
                    cnt_d = LOAD;
                end else if (tick) begin
                    if (cnt_q == ONE) state_d = P_IDLE;
                    cnt_d = cnt_q - ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= P_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb rst_n_out = (state_q != P_LOW);
endmodule

// File: rtl/wdg_sel_mux.sv
module wdg_sel_mux
    import wdg_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               fire,
    input  logic               safe_sel,
    input  logic [CODE_W-1:0]  safe_code,
    input  logic [CODE_W-1:0]  strap_code,
    input  logic               sw_sel_en,
    input  logic [FIELD_W-1:0] sw_field,
    input  logic               code_wr,
    output logic [CODE_W-1:0]  fsel_code,
    output logic               ovr_active
);
    sel_st_t           state_q, state_d;
    logic [CODE_W-1:0] ovr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_NORMAL:  if (fire) state_d = M_RECOVER;
            M_RECOVER: if (!fire && code_wr) state_d = M_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= M_NORMAL;
            ovr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire) ovr_q <= safe_sel ? safe_code : strap_code;
        end
    end

    always_comb begin
        ovr_active = (state_q == M_RECOVER);
        if (ovr_active)     fsel_code = ovr_q;
        else if (sw_sel_en) fsel_code = unpack_sw(sw_field);
        else                fsel_code = strap_code;
    end
endmodule

// File: rtl/wdt_freq_guard.sv
module wdt_freq_guard #(
    parameter int TIME_W       = 8,
    parameter int TIME_DEFAULT = 8,
    parameter int PULSE_TICKS  = 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tick,
    input  logic              pwrgd_n,
    input  logic [4:0]        strap_code,
    input  logic              sw_sel_en,
    input  logic [7:0]        sw_field,
    input  logic              code_wr,
    input  logic              safe_sel,
    input  logic [4:0]        safe_code,
    input  logic              wd_en_wr,
    input  logic              wd_en_wdata,
    input  logic              wd_time_wr,
    input  logic [TIME_W-1:0] wd_time_wdata,
    input  logic              mn_wr,
    input  logic              mn_wdata,
    output logic [4:0]        fsel_code,
    output logic              mn_en,
    output logic              wd_running,
    output logic [TIME_W-1:0] wd_time,
    output logic              wd_timeout,
    output logic              rst_out_n
);
    import wdg_pkg::*;

    logic [CODE_W-1:0] strap_q;
    logic              strap_held;
    logic              fire;
    logic              ovr_active;
    logic              mn_q;

    wdg_strap_latch u_strap (
        .clk      (clk),
        .por_n    (por_n),
        .pwrgd_n  (pwrgd_n),
        .strap_in (strap_code),
        .strap_q  (strap_q),
        .held     (strap_held)
    );

    wdg_timer #(
        .TIME_W       (TIME_W),
        .TIME_DEFAULT (TIME_DEFAULT)
    ) u_timer (
        .clk        (clk),
        .por_n      (por_n),
        .tick       (tick),
        .en_wr      (wd_en_wr),
        .en_wdata   (wd_en_wdata),
        .time_wr    (wd_time_wr),
        .time_wdata (wd_time_wdata),
        .count      (wd_time),
        .running    (wd_running),
        .fire       (fire),
        .timeout    (wd_timeout)
    );

    wdg_sel_mux u_mux (
        .clk        (clk),
        .por_n      (por_n),
        .fire       (fire),
        .safe_sel   (safe_sel),
        .safe_code  (safe_code),
        .strap_code (strap_q),
        .sw_sel_en  (sw_sel_en),
        .sw_field   (sw_field),
        .code_wr    (code_wr),
        .fsel_code  (fsel_code),
        .ovr_active (ovr_active)
    );

    wdg_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk       (clk),
        .por_n     (por_n),
        .tick      (tick),
        .start     (fire),
        .rst_n_out (rst_out_n)
    );

    // M/N programming enable: expiry outranks a same-cycle host write
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     mn_q <= 1'b0;
        else if (fire)  mn_q <= 1'b0;
        else if (mn_wr) mn_q <= mn_wdata;
    end

    always_comb mn_en = mn_q;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
    parameter int TIME_W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              tick,
    input logic              wd_en_wr,
    input logic              wd_time_wr,
    input logic              safe_sel,
    input logic [4:0]        safe_code,
    input logic [4:0]        fsel_code,
    input logic              mn_en,
    input logic              wd_running,
    input logic [TIME_W-1:0] wd_time,
    input logic              wd_timeout,
    input logic              rst_out_n,
    input logic [4:0]        strap_q,
    input logic              strap_held
);
    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        strap_held |=> $stable(strap_q));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wd_running && tick && !wd_en_wr && !wd_time_wr) |=> (wd_time == $past(wd_time) - 1'b1));

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wd_running && !wd_en_wr && !wd_time_wr) |=> $stable(wd_time));

    // R6
    timeout_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wd_timeout) |-> !wd_running);

    // R7
    safe_code_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(wd_timeout) && $past(safe_sel)) |-> (fsel_code == $past(safe_code)));

    // R8
    mn_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wd_timeout) |-> !mn_en);

    // R9
    rst_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wd_timeout) |-> !rst_out_n);
endmodule

bind wdt_freq_guard wdg_guard_chk #(.TIME_W(TIME_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .tick       (tick),
    .wd_en_wr   (wd_en_wr),
    .wd_time_wr (wd_time_wr),
    .safe_sel   (safe_sel),
    .safe_code  (safe_code),
    .fsel_code  (fsel_code),
    .mn_en      (mn_en),
    .wd_running (wd_running),
    .wd_time    (wd_time),
    .wd_timeout (wd_timeout),
    .rst_out_n  (rst_out_n),
    .strap_q    (strap_q),
    .strap_held (strap_held)
);

// File: tb/sim_wdt_freq_guard.sv
`timescale 1ns/1ps
module sim_wdt_freq_guard;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       tick = 1'b0;
    logic       pwrgd_n = 1'b1;
    logic [4:0] strap_code = 5'h13;
    logic       sw_sel_en = 1'b0;
    logic [7:0] sw_field = 8'h00;
    logic       code_wr = 1'b0;
    logic       safe_sel = 1'b0;
    logic [4:0] safe_code = 5'h00;
    logic       wd_en_wr = 1'b0;
    logic       wd_en_wdata = 1'b0;
    logic       wd_time_wr = 1'b0;
    logic [7:0] wd_time_wdata = 8'h00;
    logic       mn_wr = 1'b0;
    logic       mn_wdata = 1'b0;
    logic [4:0] fsel_code;
    logic       mn_en;
    logic       wd_running;
    logic [7:0] wd_time;
    logic       wd_timeout;
    logic       rst_out_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wdt_freq_guard #(.TIME_W(8), .TIME_DEFAULT(8), .PULSE_TICKS(2)) u0 (
        .clk(clk), .por_n(por_n), .tick(tick), .pwrgd_n(pwrgd_n),
        .strap_code(strap_code), .sw_sel_en(sw_sel_en), .sw_field(sw_field),
        .code_wr(code_wr), .safe_sel(safe_sel), .safe_code(safe_code),
        .wd_en_wr(wd_en_wr), .wd_en_wdata(wd_en_wdata),
        .wd_time_wr(wd_time_wr), .wd_time_wdata(wd_time_wdata),
        .mn_wr(mn_wr), .mn_wdata(mn_wdata), .fsel_code(fsel_code),
        .mn_en(mn_en), .wd_running(wd_running), .wd_time(wd_time),
        .wd_timeout(wd_timeout), .rst_out_n(rst_out_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1; cyc(1); tick = 1'b0;
    endtask

    task automatic wr_time(input logic [7:0] v);
        wd_time_wdata = v; wd_time_wr = 1'b1; cyc(1); wd_time_wr = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        wd_en_wdata = v; wd_en_wr = 1'b1; cyc(1); wd_en_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R3 default time", wd_time, 8);
        check("R4 idle running", wd_running, 0);
        check("R6 reset status", wd_timeout, 0);
        check("R9 reset rst_out_n", rst_out_n, 1);
        check("R1 uncaptured code", fsel_code, 0);
        check("R8 reset mn_en", mn_en, 0);
    endtask

    task automatic t_strap();
        pwrgd_n = 1'b0; cyc(1); pwrgd_n = 1'b1;
        strap_code = 5'h0A; cyc(1);
        check("R1 captured straps", fsel_code, 5'h13);
        pwrgd_n = 1'b0; cyc(2); pwrgd_n = 1'b1; cyc(1);
        check("R1 straps held", fsel_code, 5'h13);
    endtask

    task automatic t_sw_select();
        sw_sel_en = 1'b1; sw_field = 8'hA4; cyc(1);
        check("R2 field A4", fsel_code, 5'h1A);
        sw_field = 8'h50; cyc(1);
        check("R2 field 50", fsel_code, 5'h05);
        sw_field = 8'h1C; cyc(1);
        check("R2 field 1C", fsel_code, 5'h11);
    endtask

    task automatic t_count();
        wr_time(8'd3);
        check("R4 not armed", wd_running, 0);
        check("R3 time readback", wd_time, 3);
        wr_en(1'b1);
        check("R4 running", wd_running, 1);
        do_tick();
        check("R3 live count", wd_time, 2);
    endtask

    task automatic t_restart();
        wr_time(8'd6);
        check("R5 restart running", wd_running, 1);
        check("R5 restart value", wd_time, 6);
        do_tick();
        check("R5 counts from new value", wd_time, 5);
    endtask

    task automatic t_stop();
        wr_en(1'b0);
        check("R4 stopped", wd_running, 0);
        do_tick();
        check("R4 held count", wd_time, 5);
    endtask

    task automatic t_expire_safe();
        safe_sel = 1'b1; safe_code = 5'h0E;
        mn_wdata = 1'b1; mn_wr = 1'b1; cyc(1); mn_wr = 1'b0;
        check("R8 mn write", mn_en, 1);
        wr_time(8'd2); wr_en(1'b1);
        do_tick();
        check("R3 count 1", wd_time, 1);
        do_tick();
        cyc(1);
        check("R6 status set", wd_timeout, 1);
        check("R6 stopped", wd_running, 0);
        check("R7 safe code", fsel_code, 5'h0E);
        check("R8 mn cleared", mn_en, 0);
        check("R9 reset low", rst_out_n, 0);
        do_tick();
        check("R9 still low after one tick", rst_out_n, 0);
        check("R4 no count after expiry", wd_time, 0);
        do_tick();
        check("R9 released after two ticks", rst_out_n, 1);
    endtask

    task automatic t_status_clear();
        wr_time(8'd4);
        check("R6 status survives time write", wd_timeout, 1);
        check("R6 not rearmed", wd_running, 0);
        check("R7 override held", fsel_code, 5'h0E);
        wr_en(1'b1);
        check("R6 status cleared on start", wd_timeout, 0);
        check("R4 restarted", wd_running, 1);
    endtask

    task automatic t_expire_strap();
        safe_sel = 1'b0;
        code_wr = 1'b1; cyc(1); code_wr = 1'b0;
        check("R7 release to software code", fsel_code, 5'h11);
        for (int i = 0; i < 4; i++) begin
            do_tick();
            cyc(2);
        end
        check("R7 strap recovery", fsel_code, 5'h13);
        check("R6 status again", wd_timeout, 1);
        code_wr = 1'b1; cyc(1); code_wr = 1'b0;
        check("R7 released again", fsel_code, 5'h11);
    endtask

    initial begin
        cyc(3);
        por_n = 1'b1;
        cyc(1);
        t_reset();
        t_strap();
        t_sw_select();
        t_count();
        t_restart();
        t_stop();
        t_expire_safe();
        t_status_clear();
        t_expire_strap();
        cyc(4);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule